// File: doc/BRIEF.md
# Port-to-Port Mailbox Interrupt Controller

This block sits beside a two-port shared memory and turns accesses to two reserved words at the top of the address space into doorbell interrupts between the two sides. The word at the highest address belongs to the right side. The word just below it belongs to the left side. Each side leaves a message for the other by writing into the other side's word. That write raises the owner's interrupt. The owner drops its interrupt by reading its own word. The message data itself is held in the ordinary memory array, and this block only follows the strobes and addresses.

Each side also presents a busy input, which comes from the memory's contention arbiter. While a side sees busy asserted, its accesses are ignored for interrupt purposes: a write does not raise the peer's interrupt, and a read does not acknowledge its own interrupt. Both interrupt outputs are registered and active low, and the address width is a parameter.

Top module: `dp_mailbox_irq`

## Requirements
- R1: After reset, and before any qualifying access, both `l_irq_n` and `r_irq_n` are high (inactive).
- R2: A left write (`l_wr`=1, `l_busy`=0) to address 2^ADDR_W−1 drives `r_irq_n` low on the clock edge that samples it.
- R3: A right write (`r_wr`=1, `r_busy`=0) to address 2^ADDR_W−2 drives `l_irq_n` low on the clock edge that samples it.
- R4: A read by a side of its own word (left reads 2^ADDR_W−2, right reads 2^ADDR_W−1) with its busy low returns that side's interrupt output high on the sampling edge.
- R5: A read by one side of the other side's word leaves both interrupt outputs unchanged.
- R6: A write by a side whose busy input is high does not raise the peer's interrupt.
- R7: A read of its own word by a side whose busy input is high does not clear its interrupt.
- R8: If a qualifying raise and a qualifying acknowledge of the same interrupt are sampled on the same edge, the interrupt ends up active (low).
- R9: Writes to a side's own word, writes to any other address, and reads of any other address do not change either interrupt output.
- R10: The two interrupts are independent. Both can be raised together or cleared together, and each holds its state across idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_addr | input | ADDR_W | Left side address |
| l_wr | input | 1 | Left side write strobe, one cycle per access |
| l_rd | input | 1 | Left side read strobe, one cycle per access |
| l_busy | input | 1 | Left side contention busy, active high |
| r_addr | input | ADDR_W | Right side address |
| r_wr | input | 1 | Right side write strobe |
| r_rd | input | 1 | Right side read strobe |
| r_busy | input | 1 | Right side contention busy, active high |
| l_irq_n | output | 1 | Interrupt to the left side, active low, registered |
| r_irq_n | output | 1 | Interrupt to the right side, active low, registered |

## Verification
The hardest case to reach is the collision where one side posts a message on the same edge that the owner acknowledges the previous one. Busy gating also has to be shown to suppress only the side that receives busy. The bench drives both ports together within a single cycle. It places a left write to the right word in the same cycle as a right read of that word, once with the interrupt already pending and once with it idle. It then repeats the acknowledge with busy held on the owner and later released, so that both the suppressed edge and the effective edge can be seen at the outputs.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int unsigned NUM_SIDES = 2;
    localparam int unsigned SIDE_LEFT = 0;
    localparam int unsigned SIDE_RIGHT = 1;

    typedef struct packed {
        logic pending;
    } irq_state_t;
endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode #(
    parameter int unsigned ADDR_W = 13,
    parameter logic [ADDR_W-1:0] OWN_WORD = '0,
    parameter logic [ADDR_W-1:0] PEER_WORD = '1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic              busy,
    output logic              raise_peer,
    output logic              ack_own
);
    logic hit_own;
    logic hit_peer;

    always_comb begin
        hit_own    = (addr == OWN_WORD);
        hit_peer   = (addr == PEER_WORD);
        raise_peer = wr && hit_peer && !busy;
        ack_own    = rd && hit_own && !busy;
    end
endmodule

// File: rtl/mbox_irq_flag.sv
module mbox_irq_flag
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic ack,
    output logic irq_n
);
    irq_state_t state_d;
    irq_state_t state_q;

    always_comb begin
        state_d = state_q;
        if (ack) begin
            state_d.pending = 1'b0;
        end
        // raise is applied last so a posted message is never dropped
        if (raise) begin
            state_d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_n = ~state_q.pending;
endmodule

// File: rtl/dp_mailbox_irq.sv
module dp_mailbox_irq
    import mbox_pkg::*;
#(
    parameter int unsigned ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_wr,
    input  logic              l_rd,
    input  logic              l_busy,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_wr,
    input  logic              r_rd,
    input  logic              r_busy,
    output logic              l_irq_n,
    output logic              r_irq_n
);
    localparam logic [ADDR_W-1:0] RIGHT_WORD = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] LEFT_WORD  = {{(ADDR_W-1){1'b1}}, 1'b0};

    logic [ADDR_W-1:0]    side_addr [NUM_SIDES];
    logic [NUM_SIDES-1:0] side_wr;
    logic [NUM_SIDES-1:0] side_rd;
    logic [NUM_SIDES-1:0] side_busy;
    logic [NUM_SIDES-1:0] raise_peer;
    logic [NUM_SIDES-1:0] ack_own;
    logic [NUM_SIDES-1:0] irq_n_vec;

    always_comb begin
        side_addr[SIDE_LEFT]  = l_addr;
        side_addr[SIDE_RIGHT] = r_addr;
        side_wr   = {r_wr, l_wr};
        side_rd   = {r_rd, l_rd};
        side_busy = {r_busy, l_busy};
    end

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        localparam logic [ADDR_W-1:0] OWN  = (g == SIDE_LEFT) ? LEFT_WORD : RIGHT_WORD;
        localparam logic [ADDR_W-1:0] PEER = (g == SIDE_LEFT) ? RIGHT_WORD : LEFT_WORD;

        mbox_port_decode #(
            .ADDR_W   (ADDR_W),
            .OWN_WORD (OWN),
            .PEER_WORD(PEER)
        ) u_dec (
            .addr      (side_addr[g]),
            .wr        (side_wr[g]),
            .rd        (side_rd[g]),
            .busy      (side_busy[g]),
            .raise_peer(raise_peer[g]),
            .ack_own   (ack_own[g])
        );

        mbox_irq_flag u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .raise(raise_peer[NUM_SIDES-1-g]),
            .ack  (ack_own[g]),
            .irq_n(irq_n_vec[g])
        );
    end

    assign l_irq_n = irq_n_vec[SIDE_LEFT];
    assign r_irq_n = irq_n_vec[SIDE_RIGHT];
endmodule

// File: rtl/dp_mailbox_irq_chk.sv
module dp_mailbox_irq_chk #(
    parameter int unsigned ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_wr,
    input logic              l_rd,
    input logic              l_busy,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_wr,
    input logic              r_rd,
    input logic              r_busy,
    input logic              l_irq_n,
    input logic              r_irq_n
);
    localparam logic [ADDR_W-1:0] TOPW  = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] NEXTW = {{(ADDR_W-1){1'b1}}, 1'b0};

    logic post_to_r, post_to_l, ack_by_r, ack_by_l;
    assign post_to_r = l_wr && (l_addr == TOPW) && !l_busy;
    assign post_to_l = r_wr && (r_addr == NEXTW) && !r_busy;
    assign ack_by_r  = r_rd && (r_addr == TOPW) && !r_busy;
    assign ack_by_l  = l_rd && (l_addr == NEXTW) && !l_busy;

    a_r2_left_post_raises_right: assert property (@(posedge clk) disable iff (!rst_n)
        post_to_r |=> !r_irq_n);
    a_r3_right_post_raises_left: assert property (@(posedge clk) disable iff (!rst_n)
        post_to_l |=> !l_irq_n);
    a_r4_right_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_by_r && !post_to_r) |=> r_irq_n);
    a_r4_left_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_by_l && !post_to_l) |=> l_irq_n);
    a_r6_right_no_spurious_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (r_irq_n && !post_to_r) |=> r_irq_n);
    a_r6_left_no_spurious_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (l_irq_n && !post_to_l) |=> l_irq_n);
    a_r7_right_holds_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_irq_n && !ack_by_r) |=> !r_irq_n);
    a_r7_left_holds_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_irq_n && !ack_by_l) |=> !l_irq_n);
endmodule

bind dp_mailbox_irq dp_mailbox_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_addr(l_addr), .l_wr(l_wr), .l_rd(l_rd), .l_busy(l_busy),
    .r_addr(r_addr), .r_wr(r_wr), .r_rd(r_rd), .r_busy(r_busy),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
);

// File: tb/dp_mailbox_irq_test.sv
module dp_mailbox_irq_test;
    localparam int unsigned AW = 13;
    localparam logic [AW-1:0] RW = {AW{1'b1}};
    localparam logic [AW-1:0] LW = RW - 13'd1;
    localparam logic [AW-1:0] OTHER = RW - 13'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic l_wr = 0, l_rd = 0, l_busy = 0;
    logic r_wr = 0, r_rd = 0, r_busy = 0;
    logic l_irq_n, r_irq_n;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dp_mailbox_irq #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .l_addr(l_addr), .l_wr(l_wr), .l_rd(l_rd), .l_busy(l_busy),
        .r_addr(r_addr), .r_wr(r_wr), .r_rd(r_rd), .r_busy(r_busy),
        .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic idle();
        l_wr = 0; l_rd = 0; l_busy = 0; r_wr = 0; r_rd = 0; r_busy = 0;
        l_addr = '0; r_addr = '0;
    endtask

    // apply the current drive for one edge, then sample at the next negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic l_access(input logic w, input logic [AW-1:0] a, input logic b);
        l_wr = w; l_rd = !w; l_addr = a; l_busy = b;
    endtask

    task automatic r_access(input logic w, input logic [AW-1:0] a, input logic b);
        r_wr = w; r_rd = !w; r_addr = a; r_busy = b;
    endtask

    task automatic t_reset();
        check("R1 l_irq_n after reset", l_irq_n, 1'b1);
        check("R1 r_irq_n after reset", r_irq_n, 1'b1);
    endtask

    task automatic t_left_to_right();
        l_access(1, RW, 0); step();
        check("R2 r_irq_n raised", r_irq_n, 1'b0);
        check("R2 l_irq_n untouched", l_irq_n, 1'b1);
        l_access(0, RW, 0); step();
        check("R5 left peek at right word", r_irq_n, 1'b0);
        step(); step();
        check("R10 right irq held over idle", r_irq_n, 1'b0);
        r_access(1, OTHER, 0); step();
        r_access(0, LW, 0); step();
        check("R5 right peek at left word", r_irq_n, 1'b0);
        check("R5 right peek leaves left idle", l_irq_n, 1'b1);
        r_access(0, RW, 0); step();
        check("R4 right ack clears", r_irq_n, 1'b1);
    endtask

    task automatic t_right_to_left();
        r_access(1, LW, 0); step();
        check("R3 l_irq_n raised", l_irq_n, 1'b0);
        check("R3 r_irq_n untouched", r_irq_n, 1'b1);
        l_access(0, LW, 0); step();
        check("R4 left ack clears", l_irq_n, 1'b1);
    endtask

    task automatic t_busy();
        l_access(1, RW, 1); step();
        check("R6 busy left write blocked", r_irq_n, 1'b1);
        r_access(1, LW, 1); step();
        check("R6 busy right write blocked", l_irq_n, 1'b1);
        l_access(1, RW, 0); step();
        r_access(0, RW, 1); step();
        check("R7 busy right ack blocked", r_irq_n, 1'b0);
        r_access(0, RW, 0); r_busy = 0; l_busy = 1; step();
        check("R7 left busy does not block right ack", r_irq_n, 1'b1);
        r_access(1, LW, 0); step();
        l_access(0, LW, 1); step();
        check("R7 busy left ack blocked", l_irq_n, 1'b0);
        l_access(0, LW, 0); step();
        check("R7 left ack after busy drops", l_irq_n, 1'b1);
    endtask

    task automatic t_collision();
        l_access(1, RW, 0); r_access(0, RW, 0); step();
        check("R8 raise beats ack from idle", r_irq_n, 1'b0);
        l_access(1, RW, 0); r_access(0, RW, 0); step();
        check("R8 raise beats ack while pending", r_irq_n, 1'b0);
        r_access(1, LW, 0); l_access(0, LW, 0); step();
        check("R8 left raise beats ack", l_irq_n, 1'b0);
        r_access(0, RW, 0); l_access(0, LW, 0); step();
        check("R10 both cleared together l", l_irq_n, 1'b1);
        check("R10 both cleared together r", r_irq_n, 1'b1);
    endtask

    task automatic t_other_addr();
        l_access(1, LW, 0); r_access(1, RW, 0); step();
        check("R9 own-word write left", l_irq_n, 1'b1);
        check("R9 own-word write right", r_irq_n, 1'b1);
        l_access(1, OTHER, 0); r_access(1, '0, 0); step();
        check("R9 plain write l", l_irq_n, 1'b1);
        check("R9 plain write r", r_irq_n, 1'b1);
        l_access(1, RW, 0); r_access(1, LW, 0); step();
        check("R10 both raised l", l_irq_n, 1'b0);
        check("R10 both raised r", r_irq_n, 1'b0);
        l_access(0, OTHER, 0); r_access(0, LW - 13'd5, 0); step();
        check("R9 plain read l", l_irq_n, 1'b0);
        check("R9 plain read r", r_irq_n, 1'b0);
        l_access(0, LW, 0); step();
        check("R10 left ack only l", l_irq_n, 1'b1);
        check("R10 left ack only r", r_irq_n, 1'b0);
        r_access(0, RW, 0); step();
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_left_to_right();
        t_right_to_left();
        t_busy();
        t_collision();
        t_other_addr();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule